// File: doc/BRIEF.md
# SDRAM Special Command Issue Logic

This block sits inside a simple SDRAM controller, between the host access port and the command sequencer. It holds a small control register per SDRAM block: an address-mux code, a port-size code and two one-shot request bits. Software arms a request bit. The next suitable host access then launches a special command in place of a normal read or write. An armed mode-register-set request fires on the next access of either direction. An armed precharge-all request fires only on the next write. Each request bit clears itself when the sequencer signals that its command has finished.

During any command, the block drives the SDRAM address and bank lines from the host address. The mux code selects which host address bit drives the dedicated command pin of the SDRAM address bus, and which host bits form the bank select. For a mode-register-set command, software picks the mode value by picking the address of the triggering access. While a special command is in flight, further host accesses are held off with a wait signal. The block also decodes the port-size code into a byte width for the rest of the controller.

Top module: `sdram_special_cmd`

## Requirements
- R1: After reset, cmdValid and hostWait are 0, cmdCode is NOP (0), reqState is 0, and portBytes is 4.
- R2: A register write loads the fields regWrData[2:0] (mux code), [4:3] (port size), [5] (precharge-all request) and [6] (mode-set request). reqState reports {mode-set request, precharge-all request} from the cycle after the write.
- R3: With the mode-set request armed, the next accepted access, read or write, produces cmdCode MRS (3) with cmdValid high in the following cycle. sdAddr uses the same mapping from the access address as an ordinary access.
- R4: A special command keeps cmdValid high until cmdDone. Its request bit is still set in the cycle where cmdDone is high and reads 0 in the next cycle, when cmdValid is 0 and cmdCode is NOP.
- R5: With only the precharge-all request armed, a read passes through as an ordinary READ (1) and leaves the request armed.
- R6: With the precharge-all request armed, the next accepted write produces cmdCode PALL (4) with sdAddr[CMD_PIN] forced to 1. The request clears one cycle after cmdDone.
- R7: With both requests armed, the first access issues MRS. The next write after that issues PALL. Each fires exactly once, and a later write is an ordinary WRITE.
- R8: While a special command is in flight, hostWait is 1 and a held access is not taken. The access is taken on the first clock edge after the command completes.
- R9: With no request armed, an accepted access produces a one-cycle cmdValid pulse with cmdCode READ (1) or WRITE (2) in the next cycle and no wait. Outside valid cycles cmdCode is NOP.
- R10: For mux code c (0..7), sdAddr[CMD_PIN] carries hostAddr[17+c] and sdBank carries hostAddr[18+c +: BANK_W]. The other sdAddr bits i carry hostAddr[2+i].
- R11: portBytes is 4 for port size 00, 1 for 01, and 2 for 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 7 | Control register write value |
| hostReq | input | 1 | Host access request |
| hostWr | input | 1 | Host access is a write |
| hostAddr | input | 32 | Host access byte address |
| hostWait | output | 1 | Access stalled; hold the request |
| cmdDone | input | 1 | Sequencer reports the special command finished |
| cmdValid | output | 1 | Command outputs are valid |
| cmdCode | output | 3 | Command: NOP 0, READ 1, WRITE 2, MRS 3, PALL 4 |
| sdAddr | output | 13 | SDRAM address lines |
| sdBank | output | 2 | SDRAM bank select lines |
| reqState | output | 2 | Armed requests {mode-set, precharge-all} |
| portBytes | output | 3 | Decoded port width in bytes |

## Verification
On every cycle, the assertions check the following: a special command's outputs stay frozen until completion; the wait signal persists; an armed mode-set request always wins the next access; a read never turns into a precharge-all; and the port width stays one-hot. Only the bench scenarios can show these properties: the exact cycle in which a request bit clears, that each command fires exactly once, and the correct bit routing for each of the eight mux codes. They also show that a stalled access resumes once the command completes.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_MRS   = 3'd3,
    CMD_PALL  = 3'd4
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } state_e;

  // control register field positions
  localparam int FLD_MUX_LO  = 0;
  localparam int FLD_MUX_W   = 3;
  localparam int FLD_SIZE_LO = 3;
  localparam int FLD_SIZE_W  = 2;
  localparam int FLD_PALL    = 5;
  localparam int FLD_MRS     = 6;
  localparam int REG_W       = 7;

  typedef struct packed {
    logic load;
    logic clr;
    cmd_e code;
  } dpStrobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      armMrsIn,
  input  logic      armPallIn,
  input  logic      hostReq,
  input  logic      hostWr,
  input  logic      cmdDone,
  output dpStrobe_t strobe,
  output logic      cmdValid,
  output logic      hostWait,
  output logic [1:0] reqState
);
  state_e state;
  logic   mrsReq, pallReq, activeMrs, validQ;
  logic   acc, special;
  cmd_e   nextCode;

  always_comb begin
    acc      = (state == ST_IDLE) && hostReq;
    special  = 1'b0;
    nextCode = hostWr ? CMD_WRITE : CMD_READ;
    if (mrsReq) begin
      nextCode = CMD_MRS;
      special  = 1'b1;
    end else if (pallReq && hostWr) begin
      nextCode = CMD_PALL;
      special  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      mrsReq    <= 1'b0;
      pallReq   <= 1'b0;
      activeMrs <= 1'b0;
      validQ    <= 1'b0;
    end else begin
      if (acc) begin
        validQ <= 1'b1;
        if (special) begin
          state     <= ST_BUSY;
          activeMrs <= (nextCode == CMD_MRS);
        end
      end else if (state == ST_BUSY) begin
        validQ <= !cmdDone;
        if (cmdDone) begin
          state <= ST_IDLE;
          if (activeMrs) mrsReq  <= 1'b0;
          else           pallReq <= 1'b0;
        end
      end else begin
        validQ <= 1'b0;
      end
      if (regWrEn) begin
        mrsReq  <= armMrsIn;
        pallReq <= armPallIn;
      end
    end
  end

  always_comb begin
    strobe.load = acc;
    strobe.code = nextCode;
    strobe.clr  = !acc && validQ && ((state == ST_IDLE) || cmdDone);
  end

  assign cmdValid = validQ;
  assign hostWait = (state == ST_BUSY);
  assign reqState = {mrsReq, pallReq};

  AST_MRS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && activeMrs && cmdDone && !regWrEn) |=> !mrsReq); // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWait && !cmdDone) |=> hostWait); // R8
endmodule

// File: rtl/sdcmd_datapath.sv
module sdcmd_datapath
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SD_ADDR_W = 13,
  parameter int BANK_W    = 2,
  parameter int CMD_PIN   = 10,
  parameter int CMD_BASE  = 17,
  parameter int ADDR_LSB  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [FLD_MUX_W-1:0] muxCodeIn,
  input  logic [FLD_SIZE_W-1:0] portSizeIn,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  dpStrobe_t            strobe,
  output cmd_e                 cmdCode,
  output logic [SD_ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0]    sdBank,
  output logic [2:0]           portBytes
);
  localparam int IDX_W = $clog2(ADDR_W);

  logic [FLD_MUX_W-1:0]  muxCode;
  logic [FLD_SIZE_W-1:0] portSize;
  logic [SD_ADDR_W-1:0]  addrNext;
  logic [BANK_W-1:0]     bankNext;
  logic [IDX_W-1:0]      cmdIdx;
  logic                  forcePin;

  assign cmdIdx   = IDX_W'(CMD_BASE) + IDX_W'(muxCode);
  assign forcePin = (strobe.code == CMD_PALL);

  for (genvar i = 0; i < SD_ADDR_W; i++) begin : g_addr
    if (i == CMD_PIN) begin : g_cmd
      assign addrNext[i] = forcePin | hostAddr[cmdIdx];
    end else begin : g_plain
      assign addrNext[i] = hostAddr[ADDR_LSB + i];
    end
  end

  for (genvar b = 0; b < BANK_W; b++) begin : g_bank
    logic [IDX_W-1:0] bankIdx;
    assign bankIdx     = IDX_W'(CMD_BASE + 1 + b) + IDX_W'(muxCode);
    assign bankNext[b] = hostAddr[bankIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxCode  <= '0;
      portSize <= '0;
      cmdCode  <= CMD_NOP;
      sdAddr   <= '0;
      sdBank   <= '0;
    end else begin
      if (regWrEn) begin
        muxCode  <= muxCodeIn;
        portSize <= portSizeIn;
      end
      if (strobe.load) begin
        cmdCode <= strobe.code;
        sdAddr  <= addrNext;
        sdBank  <= bankNext;
      end else if (strobe.clr) begin
        cmdCode <= CMD_NOP;
      end
    end
  end

  always_comb begin
    unique case (portSize)
      2'b00:   portBytes = 3'd4;
      2'b01:   portBytes = 3'd1;
      default: portBytes = 3'd2;
    endcase
  end

  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(portBytes) == 1); // R11
  AST_PALL_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_PALL) |-> sdAddr[CMD_PIN]); // R6
endmodule

// File: rtl/sdram_special_cmd.sv
module sdram_special_cmd
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SD_ADDR_W = 13,
  parameter int BANK_W    = 2,
  parameter int CMD_PIN   = 10,
  parameter int CMD_BASE  = 17,
  parameter int ADDR_LSB  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 hostReq,
  input  logic                 hostWr,
  input  logic [ADDR_W-1:0]    hostAddr,
  output logic                 hostWait,
  input  logic                 cmdDone,
  output logic                 cmdValid,
  output logic [2:0]           cmdCode,
  output logic [SD_ADDR_W-1:0] sdAddr,
  output logic [BANK_W-1:0]    sdBank,
  output logic [1:0]           reqState,
  output logic [2:0]           portBytes
);
  dpStrobe_t strobe;
  cmd_e      codeQ;

  sdcmd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .armMrsIn (regWrData[FLD_MRS]),
    .armPallIn(regWrData[FLD_PALL]),
    .hostReq  (hostReq),
    .hostWr   (hostWr),
    .cmdDone  (cmdDone),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .hostWait (hostWait),
    .reqState (reqState)
  );

  sdcmd_datapath #(
    .ADDR_W   (ADDR_W),
    .SD_ADDR_W(SD_ADDR_W),
    .BANK_W   (BANK_W),
    .CMD_PIN  (CMD_PIN),
    .CMD_BASE (CMD_BASE),
    .ADDR_LSB (ADDR_LSB)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .muxCodeIn (regWrData[FLD_MUX_LO +: FLD_MUX_W]),
    .portSizeIn(regWrData[FLD_SIZE_LO +: FLD_SIZE_W]),
    .hostAddr  (hostAddr),
    .strobe    (strobe),
    .cmdCode   (codeQ),
    .sdAddr    (sdAddr),
    .sdBank    (sdBank),
    .portBytes (portBytes)
  );

  assign cmdCode = codeQ;

  AST_MRS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostWait && reqState[1]) |=> (cmdValid && codeQ == CMD_MRS)); // R7
  AST_READ_NO_PALL: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !hostWait && !hostWr && !reqState[1]) |=> (codeQ == CMD_READ)); // R5
  AST_SPECIAL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (codeQ == CMD_MRS || codeQ == CMD_PALL) && !cmdDone)
      |=> (cmdValid && $stable(codeQ) && $stable(sdAddr))); // R8
endmodule

// File: tb/test_sdram_special_cmd.sv
module test_sdram_special_cmd;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regWrData = '0;
  logic        hostReq = 1'b0;
  logic        hostWr = 1'b0;
  logic [31:0] hostAddr = '0;
  logic        hostWait;
  logic        cmdDone = 1'b0;
  logic        cmdValid;
  logic [2:0]  cmdCode;
  logic [12:0] sdAddr;
  logic [1:0]  sdBank;
  logic [1:0]  reqState;
  logic [2:0]  portBytes;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_special_cmd i_sdram_special_cmd (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .hostReq(hostReq), .hostWr(hostWr), .hostAddr(hostAddr), .hostWait(hostWait),
    .cmdDone(cmdDone), .cmdValid(cmdValid), .cmdCode(cmdCode), .sdAddr(sdAddr),
    .sdBank(sdBank), .reqState(reqState), .portBytes(portBytes)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] expAddr(logic [31:0] a, int c, bit pall);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = (i == 10) ? (pall | a[17 + c]) : a[2 + i];
    return r;
  endfunction

  function automatic logic [1:0] expBank(logic [31:0] a, int c);
    return 2'((a >> (18 + c)) & 32'h3);
  endfunction

  task automatic regWrite(bit mrs, bit pall, logic [1:0] size, logic [2:0] code);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = {mrs, pall, size, code};
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic access(bit wr, logic [31:0] a);
    @(negedge clk);
    hostReq = 1'b1; hostWr = wr; hostAddr = a;
    @(negedge clk);
    hostReq = 1'b0;
  endtask

  task automatic finishCmd(string req, logic [1:0] armedBefore, logic [1:0] armedAfter);
    @(negedge clk);
    cmdDone = 1'b1;
    chk({req, " armed at done"}, 32'(reqState), 32'(armedBefore));
    @(negedge clk);
    cmdDone = 1'b0;
    chk({req, " cleared"}, 32'(reqState), 32'(armedAfter));
    chk({req, " valid low"}, 32'(cmdValid), 0);
    chk({req, " code nop"}, 32'(cmdCode), 0);
    chk({req, " wait low"}, 32'(hostWait), 0);
  endtask

  task automatic tReset();
    chk("R1 valid", 32'(cmdValid), 0);
    chk("R1 code", 32'(cmdCode), 0);
    chk("R1 wait", 32'(hostWait), 0);
    chk("R1 req", 32'(reqState), 0);
    chk("R1 bytes", 32'(portBytes), 4);
  endtask

  task automatic tPortSize();
    regWrite(0, 0, 2'b01, 3'd0); chk("R11 size01", 32'(portBytes), 1);
    regWrite(0, 0, 2'b10, 3'd0); chk("R11 size10", 32'(portBytes), 2);
    regWrite(0, 0, 2'b11, 3'd0); chk("R11 size11", 32'(portBytes), 2);
    regWrite(0, 0, 2'b00, 3'd0); chk("R11 size00", 32'(portBytes), 4);
  endtask

  task automatic tNormal();
    logic [31:0] a = 32'h0153_A5C4;
    access(1, a);
    chk("R9 write valid", 32'(cmdValid), 1);
    chk("R9 write code", 32'(cmdCode), 2);
    chk("R9 write wait", 32'(hostWait), 0);
    chk("R9 write addr", 32'(sdAddr), 32'(expAddr(a, 0, 0)));
    @(negedge clk);
    chk("R9 pulse ends", 32'(cmdValid), 0);
    chk("R9 nop after", 32'(cmdCode), 0);
    access(0, ~a);
    chk("R9 read code", 32'(cmdCode), 1);
    chk("R9 read addr", 32'(sdAddr), 32'(expAddr(~a, 0, 0)));
  endtask

  task automatic tMux();
    for (int c = 0; c < 8; c++) begin
      logic [31:0] a = 32'h9E37_79B9 ^ (32'h0002_0000 << c) ^ (32'hC0 << (c * 3));
      regWrite(0, 0, 2'b00, 3'(c));
      access(c % 2 == 1, a);
      chk($sformatf("R10 addr code%0d", c), 32'(sdAddr), 32'(expAddr(a, c, 0)));
      chk($sformatf("R10 bank code%0d", c), 32'(sdBank), 32'(expBank(a, c)));
    end
  endtask

  task automatic tMrs();
    logic [31:0] a = 32'h0004_0C88;
    regWrite(1, 0, 2'b00, 3'd2);
    chk("R2 mrs armed", 32'(reqState), 2);
    access(0, a);
    chk("R3 mrs valid", 32'(cmdValid), 1);
    chk("R3 mrs code", 32'(cmdCode), 3);
    chk("R3 mrs addr", 32'(sdAddr), 32'(expAddr(a, 2, 0)));
    @(negedge clk);
    chk("R4 held valid", 32'(cmdValid), 1);
    finishCmd("R4 mrs", 2'b10, 2'b00);
  endtask

  task automatic tPall();
    logic [31:0] a = 32'h0000_1230;
    regWrite(0, 1, 2'b00, 3'd0);
    chk("R2 pall armed", 32'(reqState), 1);
    access(0, a);
    chk("R5 read passes", 32'(cmdCode), 1);
    chk("R5 still armed", 32'(reqState), 1);
    @(negedge clk);
    access(1, a);
    chk("R6 pall code", 32'(cmdCode), 4);
    chk("R6 pin forced", 32'(sdAddr[10]), 1);
    chk("R6 pall addr", 32'(sdAddr), 32'(expAddr(a, 0, 1)));
    finishCmd("R6 pall", 2'b01, 2'b00);
  endtask

  task automatic tBoth();
    regWrite(1, 1, 2'b00, 3'd0);
    access(1, 32'h40);
    chk("R7 mrs first", 32'(cmdCode), 3);
    finishCmd("R7 mrs", 2'b11, 2'b01);
    access(1, 32'h80);
    chk("R7 pall second", 32'(cmdCode), 4);
    finishCmd("R7 pall", 2'b01, 2'b00);
    access(1, 32'hC0);
    chk("R7 then ordinary", 32'(cmdCode), 2);
  endtask

  task automatic tStall();
    logic [31:0] b = 32'h0001_5558;
    regWrite(1, 0, 2'b00, 3'd0);
    access(1, 32'h100);
    @(negedge clk);
    hostReq = 1'b1; hostWr = 1'b0; hostAddr = b;
    @(negedge clk);
    chk("R8 wait", 32'(hostWait), 1);
    chk("R8 not taken", 32'(cmdCode), 3);
    @(negedge clk);
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
    chk("R8 released", 32'(hostWait), 0);
    chk("R8 gap", 32'(cmdValid), 0);
    @(negedge clk);
    hostReq = 1'b0;
    chk("R8 resumed valid", 32'(cmdValid), 1);
    chk("R8 resumed code", 32'(cmdCode), 1);
    chk("R8 resumed addr", 32'(sdAddr), 32'(expAddr(b, 0, 0)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tPortSize();
    tNormal();
    tMux();
    tMrs();
    tPall();
    tBoth();
    tStall();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule